// File: doc/BRIEF.md
# Modulo Timer with Protected Overflow Status

This block is a free-running up-counter that wraps at a programmable modulo value. It has a small register file behind a plain read/write strobe interface. The 32-bit control/status word selects:

- the counting clock source,
- a power-of-two prescaler,
- a counting-mode bit, which is stored only,
- the overflow interrupt enable.

It also holds the overflow flag, which hardware sets each time the counter wraps. The block drives a level interrupt request while both the flag and its enable are set.

Software clears the flag with a two-step handshake. First it reads the control/status word while the flag reads as 1, which arms the clear. Then it writes a 0 into the flag bit. Any overflow after the arming read cancels the pending clear, so a wrap that lands between the two accesses is never lost. Any write to the word also drops the armed state. A 0 written without arming changes nothing.

The register select is 2 bits wide:

| Select | Register |
|---|---|
| 0 | Control/status word |
| 1 | Counter value (read-only) |
| 2 | Modulo value |
| 3 | Unused, reads as zero |

Read data is combinational on the select and does not depend on the read strobe. The read strobe only marks a read for the arming step.

Top module: `modulo_timer`

## Requirements
- R1: After synchronous reset, all three registers read 0 and `irq` is 0.
- R2: The clock-source field is bits 4:3 of the control/status word and selects the counting source:
  - 0 stops counting.
  - 1 enables every clock cycle.
  - 2 enables only the cycles in which `ext_tick` is high.
  - 3 stops counting.
  - While no tick occurs, the counter holds its value.
- R3: The prescaler field is bits 2:0, holding a value p. The counter advances once per 2^p enabled source cycles, so the divisor runs from 1 to 128. Stopping the source restarts the division from zero.
- R4: The counter steps 0, 1, …, M, where M is the modulo value. On the tick after it reaches M it returns to 0, and the overflow flag (bit 7) becomes 1 on that same tick.
- R5: Reading select 0 with the read strobe while the flag is 1, then writing select 0 with bit 7 = 0, clears the flag.
- R6: A write of 0 to bit 7 without a preceding arming read leaves the flag set. A write of 1 to bit 7 never sets or changes the flag.
- R7: An overflow occurring after the arming read cancels the clear, and the later write of 0 leaves the flag set. An overflow in the same cycle as the clearing write also wins.
- R8: Any write to select 0 disarms. A write with bit 7 = 1 after an arming read, followed by a write of 0, leaves the flag set.
- R9: The enable is bit 6. `irq` equals flag AND enable, registered, so it changes one clock after either bit changes.
- R10: Bits 31:8 of the control/status word always read 0 and ignore writes. Bits 6:0 read back as written, including the mode bit 5.
- R11: The modulo register keeps the low CNT_W bits of a write and reads them back zero-extended. The counter reads back at select 1, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select (0 control/status, 1 counter, 2 modulo, 3 unused) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms the flag clear) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| ext_tick | input | 1 | External count enable, used when the source field is 2 |
| irq | output | 1 | Overflow interrupt request level |

## Verification
The bench builds the timer with CNT_W = 8. This makes a full-width rollover at modulo 255 reachable in a few hundred cycles. With the prescaler at its largest divisor of 128, a measured tick count is reachable in a similar time.

Most flag-handshake scenarios run with modulo 0 and the external source. Each `ext_tick` pulse then produces exactly one overflow at a cycle chosen by the bench. This lets the bench place an overflow before, between or on top of the arming read and the clearing write.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int REG_W     = 32;
    localparam int SEL_W     = 2;
    localparam int PS_W      = 3;
    localparam int SRC_W     = 2;
    localparam int CTRL_W    = 8;
    localparam int FLAG_BIT  = 7;
    localparam int IE_BIT    = 6;
    localparam int MODE_BIT  = 5;
    localparam int SRC_LSB   = 3;
    localparam int PS_LSB    = 0;

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF  = 2'd0,
        SRC_SYS  = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_RSVD = 2'd3
    } src_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_MOD   = 2'd2,
        SEL_NONE  = 2'd3
    } sel_e;

    // Field order matches the bit layout of the low byte.
    typedef struct packed {
        logic            flag;
        logic            ie;
        logic            mode;
        src_e            src;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_word(ctrl_t c);
        return REG_W'(c);
    endfunction

    function automatic logic src_running(src_e s);
        return (s == SRC_SYS) || (s == SRC_EXT);
    endfunction

endpackage

// File: rtl/mtmr_prescaler.sv
module mtmr_prescaler
    import mtmr_pkg::*;
#(
    parameter int PSW = PS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_i,
    input  logic           src_en_i,
    input  logic [PSW-1:0] ps_i,
    output logic           tick_o
);
    localparam int DIV_W = (1 << PSW) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W:0]   pow2;
    logic [DIV_W-1:0] lim;

    always_comb begin
        pow2   = (DIV_W+1)'(1) << ps_i;
        lim    = DIV_W'(pow2 - (DIV_W+1)'(1));
        tick_o = run_i && src_en_i && (pre_q >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pre_q <= '0;
        end else if (src_en_i) begin
            if (tick_o) pre_q <= '0;
            else        pre_q <= pre_q + DIV_W'(1);
        end
    end

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (!tick_o || $past(ps_i) == '0 || ps_i != $past(ps_i) || !$past(run_i)));

endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] mod_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap_o = tick_i && (cnt_q >= mod_i);
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (wrap_o) cnt_q <= '0;
            else        cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R2
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/mtmr_ctrl_reg.sv
module mtmr_ctrl_reg
    import mtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [CTRL_W-1:0] wdata_i,
    input  logic              ovf_i,
    output ctrl_t             ctrl_o,
    output logic              irq_o
);
    ctrl_t ctrl_q;
    logic  armed_q;
    logic  irq_q;
    logic  clear_req;

    assign clear_req = wr_i && armed_q && !wdata_i[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (ovf_i)          ctrl_q.flag <= 1'b1;
            else if (clear_req) ctrl_q.flag <= 1'b0;

            if (wr_i) begin
                ctrl_q.ie   <= wdata_i[IE_BIT];
                ctrl_q.mode <= wdata_i[MODE_BIT];
                ctrl_q.src  <= src_e'(wdata_i[SRC_LSB +: SRC_W]);
                ctrl_q.ps   <= wdata_i[PS_LSB +: PS_W];
            end

            if (ovf_i || wr_i)            armed_q <= 1'b0;
            else if (rd_i && ctrl_q.flag) armed_q <= 1'b1;

            irq_q <= ctrl_q.flag && ctrl_q.ie;
        end
    end

    assign ctrl_o = ctrl_q;
    assign irq_o  = irq_q;

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !$past(ctrl_q.flag)) |-> $past(ovf_i));

    // R7
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.flag && $past(ctrl_q.flag)) |-> ($past(wr_i) && $past(armed_q) && !$past(ovf_i)));

    // R9
    irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.ie && !$past(ctrl_q.ie)) |-> !irq_q);

endmodule

// File: rtl/modulo_timer.sv
module modulo_timer
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             ext_tick,
    output logic             irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt;
    logic             src_en;
    logic             run;
    logic             tick;
    logic             wrap;
    logic             sel_ctrl;
    logic             unused_bits;

    assign unused_bits = ^reg_wdata;
    assign sel_ctrl    = (sel_e'(reg_sel) == SEL_CTRL);
    assign run         = src_running(ctrl.src);

    always_comb begin
        case (ctrl.src)
            SRC_SYS: src_en = 1'b1;
            SRC_EXT: src_en = ext_tick;
            default: src_en = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                         mod_q <= '0;
        else if (reg_wr && sel_e'(reg_sel) == SEL_MOD)   mod_q <= reg_wdata[CNT_W-1:0];
    end

    mtmr_prescaler #(.PSW(PS_W)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .run_i    (run),
        .src_en_i (src_en),
        .ps_i     (ctrl.ps),
        .tick_o   (tick)
    );

    mtmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .mod_i  (mod_q),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    mtmr_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (reg_wr && sel_ctrl),
        .rd_i    (reg_rd && sel_ctrl),
        .wdata_i (reg_wdata[CTRL_W-1:0]),
        .ovf_i   (wrap),
        .ctrl_o  (ctrl),
        .irq_o   (irq)
    );

    always_comb begin
        case (sel_e'(reg_sel))
            SEL_CTRL:  reg_rdata = ctrl_word(ctrl);
            SEL_COUNT: reg_rdata = 32'(cnt);
            SEL_MOD:   reg_rdata = 32'(mod_q);
            default:   reg_rdata = '0;
        endcase
    end

    // R2
    stopped_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run)) |-> $stable(cnt));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd0) |-> (reg_rdata[31:8] == 24'd0));

endmodule

// File: tb/test_modulo_timer.sv
module test_modulo_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_tick = 1'b0;
    logic        irq;

    int total = 0;
    int failed = 0;

    localparam logic [1:0] S_CTRL = 2'd0, S_CNT = 2'd1, S_MOD = 2'd2, S_NONE = 2'd3;
    localparam logic [31:0] EXT = 32'h10, SYS = 32'h08, IE = 32'h40, FLG = 32'h80;

    always #4 clk = ~clk;

    modulo_timer #(.CNT_W(8)) i_modulo_timer (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_tick(ext_tick), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; reg_wr = 0; reg_rd = 0; reg_sel = 0; reg_wdata = 0; ext_tick = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    function automatic logic [31:0] flag_of(input logic [31:0] w);
        return {31'd0, w[7]};
    endfunction

    // R1
    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        peek(S_CTRL, v); chk("R1 ctrl", v, 0);
        peek(S_CNT, v);  chk("R1 count", v, 0);
        peek(S_MOD, v);  chk("R1 modulo", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    // R3: system source, enabled cycles = n + 2, ticks = (n + 2) >> p
    task automatic t_prescale(input int p, input int n);
        logic [31:0] v;
        do_reset();
        bus_write(S_MOD, 32'd255);
        bus_write(S_CTRL, SYS | 32'(p));
        repeat (n) @(negedge clk);
        bus_write(S_CTRL, 32'(p));
        peek(S_CNT, v);
        chk($sformatf("R3 ps=%0d count", p), v, 32'((n + 2) >> p));
    endtask

    // R2
    task automatic t_sources();
        logic [31:0] v;
        do_reset();
        bus_write(S_MOD, 32'd255);
        bus_write(S_CTRL, 32'h00);
        repeat (20) @(negedge clk);
        pulse();
        peek(S_CNT, v); chk("R2 source off", v, 0);
        bus_write(S_CTRL, 32'h18);
        repeat (20) @(negedge clk);
        pulse(); pulse();
        peek(S_CNT, v); chk("R2 source 3 stopped", v, 0);
        bus_write(S_CTRL, EXT);
        repeat (5) begin pulse(); @(negedge clk); end
        repeat (10) @(negedge clk);
        peek(S_CNT, v); chk("R2 ext five pulses", v, 5);
        do_reset();
        bus_write(S_MOD, 32'd255);
        bus_write(S_CTRL, EXT | 32'd1);
        repeat (6) pulse();
        peek(S_CNT, v); chk("R2 R3 ext with ps=1", v, 3);
    endtask

    // R4
    task automatic t_wrap();
        logic [31:0] v;
        do_reset();
        bus_write(S_MOD, 32'd3);
        bus_write(S_CTRL, SYS);
        repeat (3) @(negedge clk);
        peek(S_CNT, v);  chk("R4 count at modulo", v, 3);
        peek(S_CTRL, v); chk("R4 flag before wrap", flag_of(v), 0);
        @(negedge clk);
        peek(S_CNT, v);  chk("R4 count wrapped", v, 0);
        peek(S_CTRL, v); chk("R4 flag on wrap", flag_of(v), 1);
        do_reset();
        bus_write(S_MOD, 32'd255);
        bus_write(S_CTRL, SYS);
        repeat (254) @(negedge clk);
        bus_write(S_CTRL, 32'h00);
        peek(S_CNT, v);  chk("R4 full width rollover", v, 0);
        peek(S_CTRL, v); chk("R4 flag after rollover", flag_of(v), 1);
    endtask

    // R5 R6
    task automatic t_clear();
        logic [31:0] v;
        do_reset();
        bus_write(S_CTRL, EXT);
        pulse();
        peek(S_CTRL, v); chk("R5 flag set", flag_of(v), 1);
        bus_write(S_CTRL, EXT);
        peek(S_CTRL, v); chk("R6 unarmed zero write ignored", flag_of(v), 1);
        bus_read(S_CTRL, v); chk("R5 arming read sees flag", flag_of(v), 1);
        bus_write(S_CTRL, EXT);
        peek(S_CTRL, v); chk("R5 flag cleared", flag_of(v), 0);
        bus_write(S_CTRL, EXT | FLG);
        peek(S_CTRL, v); chk("R6 writing one no effect", flag_of(v), 0);
    endtask

    // R7
    task automatic t_race();
        logic [31:0] v;
        do_reset();
        bus_write(S_CTRL, EXT);
        pulse();
        bus_read(S_CTRL, v);
        pulse();
        bus_write(S_CTRL, EXT);
        peek(S_CTRL, v); chk("R7 overflow between cancels clear", flag_of(v), 1);
        bus_read(S_CTRL, v);
        @(negedge clk);
        reg_sel = S_CTRL; reg_wdata = EXT; reg_wr = 1'b1; ext_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ext_tick = 1'b0;
        peek(S_CTRL, v); chk("R7 same-cycle overflow wins", flag_of(v), 1);
        bus_read(S_CTRL, v);
        bus_write(S_CTRL, EXT);
        peek(S_CTRL, v); chk("R7 later handshake clears", flag_of(v), 0);
    endtask

    // R8
    task automatic t_disarm();
        logic [31:0] v;
        do_reset();
        bus_write(S_CTRL, EXT);
        pulse();
        bus_read(S_CTRL, v);
        bus_write(S_CTRL, EXT | FLG);
        bus_write(S_CTRL, EXT);
        peek(S_CTRL, v); chk("R8 write disarms", flag_of(v), 1);
    endtask

    // R9
    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        bus_write(S_CTRL, EXT);
        pulse();
        chk("R9 irq masked", {31'd0, irq}, 0);
        bus_write(S_CTRL, EXT | IE);
        chk("R9 irq one clock late", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R9 irq raised", {31'd0, irq}, 1);
        bus_read(S_CTRL, v);
        bus_write(S_CTRL, EXT | IE);
        chk("R9 irq held one clock", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R9 irq dropped", {31'd0, irq}, 0);
        pulse();
        chk("R9 irq lags flag", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R9 irq on new flag", {31'd0, irq}, 1);
    endtask

    // R10 R11
    task automatic t_fields();
        logic [31:0] v;
        do_reset();
        bus_write(S_CTRL, 32'hFFFF_FF27);
        peek(S_CTRL, v); chk("R10 reserved zero, fields kept", v, 32'h27);
        bus_write(S_MOD, 32'h1234_56AB);
        peek(S_MOD, v);  chk("R11 modulo width", v, 32'hAB);
        peek(S_NONE, v); chk("R11 select 3 zero", v, 0);
        peek(S_CNT, v);  chk("R11 counter idle", v, 0);
    endtask

    initial begin
        #(8 * 150000);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        t_reset();
        t_prescale(0, 8);
        t_prescale(3, 30);
        t_prescale(7, 254);
        t_sources();
        t_wrap();
        t_clear();
        t_race();
        t_disarm();
        t_irq();
        t_fields();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule